// File: doc/BRIEF.md
# Dynamic VID Reference Stepper

This block converts a 5-bit voltage-identification code into the step index that drives a regulator's reference DAC. The index runs from 0, which is 1.100 V, to 30, which is 1.850 V. Each index step is 25 mV. The block acts only on a strobe that marks the start of each phase-1 switching cycle.

A new code is accepted only after the same value has been sampled at two strobes in a row. Once a code is accepted, the reference does not jump to it. It walks toward the new target one index every second strobe, so the output voltage ramps with no overshoot. The code 11111 is reserved as a no-load request. When it is accepted, the block raises a shutdown output and leaves the reference target alone. Any other accepted code clears that request.

The block powers up on the target directly. On the first clock edge after reset it loads the current code as both the reference and the target, with no ramp.

Top module: `dvid_ref_stepper`

## Requirements
- R1: `ref_idx_o` equals 30 minus the accepted code. Code 00000 gives index 30 (1.850 V) and code 11110 gives index 0 (1.100 V). The index never exceeds 30.
- R2: When code 11111 is accepted, `shdn_o` goes high and the reference target stays where it was. When any other code is accepted, `shdn_o` goes low. `shdn_o` changes only on a clock where a strobe is taken.
- R3: `vid_i` is sampled only on clocks where `cyc_strobe_i` and `en_i` are both high. A code that changes and returns between two strobes has no effect.
- R4: A code is accepted at the second of two consecutive taken strobes that both sample the same value, provided that value differs from the code already accepted. A value seen at only one strobe changes nothing.
- R5: Let A be the strobe at which a code is accepted, and n the distance between the reference and the new target. The reference moves one index toward the target at strobes A+2, A+4, and so on, and reaches it at strobe A+2n. It never moves by more than one index per clock.
- R6: `busy_o` is high exactly while the reference index differs from the accepted target index.
- R7: A new code accepted in the middle of a ramp restarts the step phase. The next step comes two strobes after the new acceptance and starts from the present reference, in whichever direction the new target lies.
- R8: While reset is asserted, all outputs are 0. On the first clock edge after reset is released, the reference and target load directly from `vid_i`. If that code is 11111, the index loads as 0 and `shdn_o` goes high.
- R9: While `en_i` is low, strobes are ignored: nothing is sampled and no step is taken. After `en_i` returns high, a changed code still needs two taken strobes before it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_strobe_i | input | 1 | One-clock pulse at the start of each phase-1 switching cycle |
| en_i | input | 1 | Enables strobe processing |
| vid_i | input | 5 | Voltage-identification code |
| ref_idx_o | output | 5 | Reference step index, 0 = 1.100 V, 30 = 1.850 V |
| busy_o | output | 1 | Reference has not yet reached the target |
| shdn_o | output | 1 | No-load shutdown request |

## Verification
All three outputs are registered. Each one updates on the clock edge that takes a strobe, or on the first edge after reset for the initial load. The bench drives each strobe for one clock and reads the outputs at the falling edge that follows.

The expected results are timed in strobes counted from a code change. Acceptance falls on the second strobe. Each later step falls on every second strobe after that, so the final index is due at strobe 2+2n.

The bench computes those strobe numbers arithmetically for each start and target pair in its sweep. It compares the outputs after every strobe, including the strobes where nothing is due to change.

// File: rtl/dvid_pkg.sv
package dvid_pkg;
  localparam int unsigned VID_W = 5;
  localparam int unsigned TOP_IDX = (1 << VID_W) - 2;
  typedef logic [VID_W-1:0] vid_t;
  localparam vid_t SHDN_CODE = '1;

  function automatic vid_t code_to_idx(vid_t c);
    return vid_t'(TOP_IDX) - c;
  endfunction
endpackage

// File: rtl/dvid_qual.sv
module dvid_qual
  import dvid_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  input  vid_t vid_i,
  output logic accept_o,
  output logic shdn_o
);
  vid_t seen_q, acc_q;

  // accept: same value at two consecutive taken strobes, differs from accepted
  assign accept_o = tick_i && (vid_i == seen_q) && (vid_i != acc_q);
  assign shdn_o   = (acc_q == SHDN_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      acc_q  <= '0;
    end else if (load_i) begin
      seen_q <= vid_i;
      acc_q  <= vid_i;
    end else if (tick_i) begin
      seen_q <= vid_i;
      if (accept_o) acc_q <= vid_i;
    end
  end
endmodule

// File: rtl/dvid_ramp.sv
module dvid_ramp #(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned STEP_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic             tick_i,
  input  logic             retarget_i,
  input  logic [IDX_W-1:0] tgt_idx_i,
  output logic [IDX_W-1:0] ref_o,
  output logic             busy_o
);
  localparam int unsigned DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_DIV - 1);

  logic [IDX_W-1:0] ref_q, tgt_q, ref_next;
  logic [DIV_W-1:0] div_q;
  logic             step_due;

  assign busy_o   = (ref_q != tgt_q);
  assign step_due = busy_o && (div_q == DIV_LAST);
  assign ref_next = (tgt_q > ref_q) ? ref_q + 1'b1 : ref_q - 1'b1;
  assign ref_o    = ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      tgt_q <= '0;
      div_q <= '0;
    end else if (load_i) begin
      ref_q <= load_idx_i;
      tgt_q <= load_idx_i;
      div_q <= '0;
    end else if (tick_i) begin
      if (retarget_i) begin
        tgt_q <= tgt_idx_i;
        div_q <= '0;
      end else if (step_due) begin
        ref_q <= ref_next;
        div_q <= '0;
      end else if (busy_o) begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dvid_ref_stepper.sv
module dvid_ref_stepper
  import dvid_pkg::*;
#(
  parameter int unsigned STEP_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_strobe_i,
  input  logic             en_i,
  input  logic [VID_W-1:0] vid_i,
  output logic [VID_W-1:0] ref_idx_o,
  output logic             busy_o,
  output logic             shdn_o
);
  logic init_q, tick, accept, retarget;
  vid_t load_idx, tgt_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b1;
    else         init_q <= 1'b0;
  end

  assign tick     = cyc_strobe_i && en_i && !init_q;
  assign tgt_idx  = code_to_idx(vid_i);
  assign load_idx = (vid_i == SHDN_CODE) ? '0 : tgt_idx;
  assign retarget = accept && (vid_i != SHDN_CODE);

  dvid_qual u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (init_q),
    .tick_i   (tick),
    .vid_i    (vid_i),
    .accept_o (accept),
    .shdn_o   (shdn_o)
  );

  dvid_ramp #(.IDX_W(VID_W), .STEP_DIV(STEP_DIV)) u_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (init_q),
    .load_idx_i (load_idx),
    .tick_i     (tick),
    .retarget_i (retarget),
    .tgt_idx_i  (tgt_idx),
    .ref_o      (ref_idx_o),
    .busy_o     (busy_o)
  );
endmodule

// File: rtl/dvid_ref_stepper_chk.sv
module dvid_ref_stepper_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cyc_strobe_i,
  input logic       en_i,
  input logic [4:0] vid_i,
  input logic [4:0] ref_idx_o,
  input logic       busy_o,
  input logic       shdn_o
);
  logic [1:0] age_q;
  logic       live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end
  assign live = (age_q == 2'd2);

  AST_REF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_idx_o <= 5'd30); // R1

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> (ref_idx_o == $past(ref_idx_o) || ref_idx_o == $past(ref_idx_o) + 5'd1
              || ref_idx_o == $past(ref_idx_o) - 5'd1)); // R5

  AST_REF_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !$past(cyc_strobe_i && en_i)) |-> $stable(ref_idx_o)); // R3

  AST_EN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !$past(en_i)) |-> ($stable(ref_idx_o) && $stable(shdn_o))); // R9

  AST_SHDN_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !$past(cyc_strobe_i)) |-> $stable(shdn_o)); // R2

  AST_SHDN_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shdn_o) |-> ($past(vid_i) == 5'h1f)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !$past(busy_o) && !$past(cyc_strobe_i)) |-> !busy_o); // R6
endmodule

bind dvid_ref_stepper dvid_ref_stepper_chk chk_i (.*);

// File: tb/dvid_ref_stepper_tb.sv
`timescale 1ns/1ps
module dvid_ref_stepper_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic       en = 1'b1;
  logic [4:0] vid = '0;
  logic [4:0] ref_idx;
  logic       busy, shdn;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dvid_ref_stepper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_strobe_i(strobe), .en_i(en),
    .vid_i(vid), .ref_idx_o(ref_idx), .busy_o(busy), .shdn_o(shdn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int r, input int b, input int s);
    chk({req, " ref"}, int'(ref_idx), r);
    chk({req, " busy"}, int'(busy), b);
    chk({req, " shdn"}, int'(shdn), s);
  endtask

  task automatic do_reset(input logic [4:0] code);
    @(negedge clk);
    rst_n = 1'b0; vid = code; strobe = 1'b0;
    @(negedge clk);
    chk_out("R8 in reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one taken strobe; returns at the falling edge after it
  task automatic pulse();
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic ramp_pair(input int a, input int b);
    int ia, ib, n, k, r;
    ia = 30 - a; ib = 30 - b;
    n = (ia > ib) ? ia - ib : ib - ia;
    do_reset(5'(a));
    chk_out("R8 load", ia, 0, 0);
    vid = 5'(b);
    for (int s = 1; s <= 3 + 2 * n; s++) begin
      pulse();
      k = (s < 2) ? 0 : (((s - 2) / 2 < n) ? (s - 2) / 2 : n);
      r = (ib >= ia) ? ia + k : ia - k;
      chk("R5 R1 ramp ref", int'(ref_idx), r);
      chk("R6 R4 busy", int'(busy), (s >= 2 && k < n) ? 1 : 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R1 R5 R6 R4 sweep: every start code to several targets
    for (int a = 0; a <= 30; a++) begin
      ramp_pair(a, 0);
      ramp_pair(a, 30);
      ramp_pair(a, 15);
      ramp_pair(a, (a + 1) % 31);
      ramp_pair(a, a);
    end

    // R8 reset with shutdown code
    do_reset(5'h1f);
    chk_out("R8 shdn load", 0, 0, 1);

    // R2 shutdown accepted, target kept, then cleared
    do_reset(5'd10);
    vid = 5'h1f;
    pulse(); chk_out("R2 first sample", 20, 0, 0);
    pulse(); chk_out("R2 shdn set", 20, 0, 1);
    pulse(); chk_out("R2 shdn held", 20, 0, 1);
    vid = 5'd12;
    pulse(); chk_out("R2 shdn pending", 20, 0, 1);
    pulse(); chk_out("R2 shdn clear", 20, 1, 0);
    pulse(); pulse(); chk_out("R2 step", 19, 1, 0);
    pulse(); pulse(); chk_out("R2 done", 18, 0, 0);

    // R4 one-strobe glitch ignored
    do_reset(5'd5);
    vid = 5'd9; pulse();
    vid = 5'd5;
    for (int i = 0; i < 4; i++) begin
      pulse(); chk_out("R4 glitch", 25, 0, 0);
    end

    // R3 changes between strobes ignored
    do_reset(5'd5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); vid = 5'd9;
      @(negedge clk); @(negedge clk); vid = 5'd5;
      pulse(); chk_out("R3 between strobes", 25, 0, 0);
    end

    // R9 enable low ignores strobes
    do_reset(5'd5);
    en = 1'b0; vid = 5'd9;
    for (int i = 0; i < 3; i++) begin
      pulse(); chk_out("R9 disabled", 25, 0, 0);
    end
    en = 1'b1;
    pulse(); chk_out("R9 first enabled", 25, 0, 0);
    pulse(); chk_out("R9 accepted", 25, 1, 0);

    // R7 retarget mid-ramp, then reverse direction
    do_reset(5'd0);
    vid = 5'd30;
    for (int i = 0; i < 6; i++) pulse();
    chk_out("R7 pre", 28, 1, 0);
    vid = 5'd20;
    pulse(); chk_out("R7 seen", 28, 1, 0);
    pulse(); chk_out("R7 accept", 28, 1, 0);
    pulse(); chk_out("R7 hold", 28, 1, 0);
    pulse(); chk_out("R7 step1", 27, 1, 0);
    pulse(); pulse(); chk_out("R7 step2", 26, 1, 0);
    vid = 5'd0;
    pulse(); chk_out("R7 rev seen", 26, 1, 0);
    pulse(); chk_out("R7 rev accept", 26, 1, 0);
    pulse(); chk_out("R7 rev hold", 26, 1, 0);
    pulse(); chk_out("R7 rev up", 27, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule